// File: doc/BRIEF.md
# Programmable-format serial receiver

This block receives asynchronous characters from an NRZ serial line that rests high. A falling edge starts a frame. The block confirms the start bit at its middle sample and then samples each following bit at the centre of its bit period, using a 16x oversampling tick supplied from outside. The control fields set the frame shape, and that shape can change between frames. The fields are the character length (1 to 8 bits), an optional address/data marker bit, optional parity with a selectable sense, and one or two stop bits.

When a frame ends, the block presents the character right-aligned on a parallel output. It reports the marker bit on its own flag, apart from the data, and raises parity-error and framing-error flags. A one-cycle valid strobe marks each completed frame. A loopback select takes the serial stream from an internal transmitter path in place of the pin. A run input that is held low keeps the receiver and all of its outputs cleared, so the configuration can be changed safely while it is low.

Top module: `serial_frame_rx`

## Requirements
- R1: A frame starts when the selected line is seen low while idle. If the line is high again at the middle sample of the start bit (8 ticks later), the event is discarded and no frame is reported.
- R2: The character length is `len_sel`+1 bits, received least significant bit first. The character appears right-aligned on `rx_data`, and every bit of `rx_data` at or above the configured length reads 0.
- R3: With `addr_mode`=1, one marker bit follows the data bits, and its value is reported on `rx_addr` (1 = address, 0 = data). With `addr_mode`=0 no such bit is expected and `rx_addr` reads 0.
- R4: With `par_en`=1, a parity bit follows the data bits, or follows the marker bit when that bit is present. Parity covers the data bits and the marker bit. `par_even`=1 asks for an even count of ones over these bits plus the parity bit, and `par_even`=0 asks for an odd count. A mismatch sets `par_err`. With `par_en`=0, `par_err` stays 0.
- R5: `two_stop` selects two stop bits when 1 and one stop bit when 0. `frm_err` is set when any expected stop bit samples low.
- R6: With `lb_en`=1, the receiver reads `lb_line` and ignores `rx_pin`.
- R7: While `run` is 0, the receiver stays idle, any frame in progress is abandoned, and `rx_data`, `rx_addr`, `par_err`, `frm_err` and `rx_valid` are all 0.
- R8: `rx_valid` is high for exactly one clock per completed frame, in the cycle after the tick that samples the last stop bit. The data and flags update in that same cycle and hold until the next frame completes.
- R9: After `rst_n` is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | 0 holds the receiver in reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_pin | input | 1 | Serial input pin, idle high |
| lb_line | input | 1 | Internal loopback serial stream |
| lb_en | input | 1 | 1 selects lb_line as the input |
| len_sel | input | 3 | Character length minus one |
| addr_mode | input | 1 | 1 enables the address/data marker bit |
| par_en | input | 1 | 1 enables the parity bit |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| two_stop | input | 1 | 1 two stop bits, 0 one stop bit |
| rx_data | output | 8 | Received character, unused upper bits 0 |
| rx_valid | output | 1 | One-cycle strobe per completed frame |
| rx_addr | output | 1 | Received marker bit |
| par_err | output | 1 | Parity mismatch in the last frame |
| frm_err | output | 1 | Low stop bit in the last frame |

## Verification
The parity check and the stop-bit check are both judged on the same valid strobe, so the two error flags can be raised in the same cycle. The bench sends a frame with its parity bit inverted and its second stop bit driven low. It expects both flags to be set together, with the data still correct. The bench also drops `run` in the middle of a frame that follows an error frame. It expects no strobe, and it expects the flags left over from the error frame to clear.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       os_tick,
  input  logic       rx_pin,
  input  logic       lb_line,
  input  logic       lb_en,
  input  logic [2:0] len_sel,
  input  logic       addr_mode,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_addr,
  output logic       par_err,
  output logic       frm_err
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_t;
  st_t st;
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [9:0]    bits;
  logic          second, ferr;

  wire       line_in = lb_en ? lb_line : rx_pin;
  wire       line    = sync_q[1];
  wire [3:0] apos    = {1'b0, len_sel} + 4'd1;
  wire [3:0] ppos    = apos + {3'b0, addr_mode};
  wire [3:0] nbits   = ppos + {3'b0, par_en};
  wire [7:0] mask    = 8'hFF >> (3'd7 - len_sel);
  wire       abit    = addr_mode & bits[apos];
  wire       pvec    = ^(bits[7:0] & mask) ^ abit ^ bits[ppos];
  wire       perr    = par_en & (par_even ? pvec : ~pvec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sync_q <= 2'b11; cnt <= '0; idx <= '0; bits <= '0;
      second <= 1'b0; ferr <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; rx_addr <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
    end else if (!run) begin
      st <= S_IDLE; sync_q <= 2'b11; cnt <= '0; idx <= '0; bits <= '0;
      second <= 1'b0; ferr <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; rx_addr <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      sync_q   <= {sync_q[0], line_in};
      if (os_tick) begin
        case (st)
          S_IDLE:
            if (!line) begin
              st  <= S_START;
              cnt <= '0;
            end
          S_START:
            if (cnt == HALF) begin
              cnt  <= '0;
              idx  <= '0;
              bits <= '0;
              st   <= line ? S_IDLE : S_BITS;
            end else cnt <= cnt + 1'b1;
          S_BITS:
            if (cnt == LAST) begin
              cnt       <= '0;
              bits[idx] <= line;
              idx       <= idx + 4'd1;
              if (idx == nbits - 4'd1) begin
                st     <= S_STOP;
                second <= 1'b0;
                ferr   <= 1'b0;
              end
            end else cnt <= cnt + 1'b1;
          S_STOP:
            if (cnt == LAST) begin
              cnt <= '0;
              if (two_stop && !second) begin
                second <= 1'b1;
                ferr   <= ~line;
              end else begin
                st       <= S_IDLE;
                rx_valid <= 1'b1;
                rx_data  <= bits[7:0] & mask;
                rx_addr  <= abit;
                par_err  <= perr;
                frm_err  <= ferr | ~line;
              end
            end else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       os_tick,
  input logic [2:0] len_sel,
  input logic       addr_mode,
  input logic       par_en,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_addr,
  input logic       par_err,
  input logic       frm_err
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R8
  valid_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(os_tick));
  // R7
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!rx_valid && !par_err && !frm_err && !rx_addr && rx_data == 8'h00));
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((16'(rx_data) >> (len_sel + 3'd1)) == 16'h0) || len_sel == 3'd7);
  // R3
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !addr_mode) |-> !rx_addr);
  // R4
  no_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !par_en) |-> !par_err);
endmodule

bind serial_frame_rx serial_frame_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .os_tick(os_tick), .len_sel(len_sel),
  .addr_mode(addr_mode), .par_en(par_en), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_addr(rx_addr), .par_err(par_err), .frm_err(frm_err)
);

// File: tb/serial_frame_rx_tb.sv
`timescale 1ns/1ps
module serial_frame_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, os_tick = 1'b0;
  logic rx_pin = 1'b1, lb_line = 1'b1, lb_en = 1'b0;
  logic [2:0] len_sel = 3'd7;
  logic addr_mode = 1'b0, par_en = 1'b0, par_even = 1'b0, two_stop = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, rx_addr, par_err, frm_err;

  int checks = 0, errors = 0, vcount = 0, wide = 0;
  logic [7:0] c_data; logic c_addr, c_pe, c_fe, prev_v = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .os_tick(os_tick), .rx_pin(rx_pin),
    .lb_line(lb_line), .lb_en(lb_en), .len_sel(len_sel), .addr_mode(addr_mode),
    .par_en(par_en), .par_even(par_even), .two_stop(two_stop), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_addr(rx_addr), .par_err(par_err), .frm_err(frm_err)
  );

  initial forever begin
    @(negedge clk);
    os_tick = ~os_tick;
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      vcount++;
      c_data = rx_data; c_addr = rx_addr; c_pe = par_err; c_fe = frm_err;
      if (prev_v) wide++;
    end
    prev_v = rx_valid;
  end

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", msg, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    if (lb_en) lb_line = b; else rx_pin = b;
    repeat (32) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic a, input logic bad_par, input logic bad_stop);
    logic [7:0] m;
    logic pb;
    m  = 8'hFF >> (3'd7 - len_sel);
    pb = ^(d & m) ^ (addr_mode & a);
    if (!par_even) pb = ~pb;
    put_bit(1'b0);
    for (int i = 0; i <= int'(len_sel); i++) put_bit(d[i]);
    if (addr_mode) put_bit(a);
    if (par_en) put_bit(pb ^ bad_par);
    put_bit(two_stop ? 1'b1 : ~bad_stop);
    if (two_stop) put_bit(~bad_stop);
    put_bit(1'b1);
  endtask

  task automatic expect_frame(input string tag, input int v0, input logic [7:0] d,
                              input logic a, input logic pe, input logic fe);
    check(vcount == v0 + 1, {tag, " valid count"}, vcount, v0 + 1);
    check(c_data == d, {tag, " data"}, c_data, d);
    check(c_addr == a, {tag, " addr flag"}, c_addr, a);
    check(c_pe == pe, {tag, " parity err"}, c_pe, pe);
    check(c_fe == fe, {tag, " framing err"}, c_fe, fe);
  endtask

  task automatic t_reset();
    check(rx_data == 8'h00 && !rx_valid && !rx_addr && !par_err && !frm_err,
          "R9 reset outputs", {rx_data, rx_valid, rx_addr, par_err, frm_err}, 0);
  endtask

  task automatic t_lengths();
    int v;
    len_sel = 3'd7; v = vcount; send_frame(8'hA5, 1'b0, 1'b0, 1'b0);
    expect_frame("R2 R8 8-bit", v, 8'hA5, 1'b0, 1'b0, 1'b0);
    len_sel = 3'd4; v = vcount; send_frame(8'hFF, 1'b0, 1'b0, 1'b0);
    expect_frame("R2 5-bit upper zero", v, 8'h1F, 1'b0, 1'b0, 1'b0);
    len_sel = 3'd0; v = vcount; send_frame(8'h01, 1'b0, 1'b0, 1'b0);
    expect_frame("R2 1-bit", v, 8'h01, 1'b0, 1'b0, 1'b0);
    len_sel = 3'd7;
  endtask

  task automatic t_addr();
    int v;
    addr_mode = 1'b1; len_sel = 3'd6;
    v = vcount; send_frame(8'h3C, 1'b1, 1'b0, 1'b0);
    expect_frame("R3 address frame", v, 8'h3C, 1'b1, 1'b0, 1'b0);
    v = vcount; send_frame(8'h7F, 1'b0, 1'b0, 1'b0);
    expect_frame("R3 data frame", v, 8'h7F, 1'b0, 1'b0, 1'b0);
    addr_mode = 1'b0; len_sel = 3'd7;
  endtask

  task automatic t_parity();
    int v;
    par_en = 1'b1; par_even = 1'b1;
    v = vcount; send_frame(8'h37, 1'b0, 1'b0, 1'b0);
    expect_frame("R4 even good", v, 8'h37, 1'b0, 1'b0, 1'b0);
    par_even = 1'b0;
    v = vcount; send_frame(8'h37, 1'b0, 1'b0, 1'b0);
    expect_frame("R4 odd good", v, 8'h37, 1'b0, 1'b0, 1'b0);
    v = vcount; send_frame(8'h81, 1'b0, 1'b1, 1'b0);
    expect_frame("R4 odd bad", v, 8'h81, 1'b0, 1'b1, 1'b0);
    addr_mode = 1'b1; par_even = 1'b1;
    v = vcount; send_frame(8'h00, 1'b1, 1'b0, 1'b0);
    expect_frame("R4 parity over marker", v, 8'h00, 1'b1, 1'b0, 1'b0);
    addr_mode = 1'b0; par_en = 1'b0;
  endtask

  task automatic t_stops();
    int v;
    two_stop = 1'b0;
    v = vcount; send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
    expect_frame("R5 single stop low", v, 8'h5A, 1'b0, 1'b0, 1'b1);
    two_stop = 1'b1;
    v = vcount; send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
    expect_frame("R5 two stops good", v, 8'h5A, 1'b0, 1'b0, 1'b0);
    v = vcount; send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
    expect_frame("R5 second stop low", v, 8'hC3, 1'b0, 1'b0, 1'b1);
    two_stop = 1'b0;
  endtask

  task automatic t_both_errors();
    int v;
    par_en = 1'b1; par_even = 1'b1; two_stop = 1'b1;
    v = vcount; send_frame(8'h96, 1'b0, 1'b1, 1'b1);
    expect_frame("R4 R5 both errors", v, 8'h96, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_run_drop();
    int v;
    v = vcount;
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    run = 1'b0;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    check(vcount == v, "R7 no strobe while held", vcount, v);
    check(!par_err && !frm_err && rx_data == 8'h00 && !rx_addr, "R7 outputs cleared",
          {rx_data, rx_addr, par_err, frm_err}, 0);
    run = 1'b1; par_en = 1'b0; two_stop = 1'b0;
    put_bit(1'b1);
    v = vcount; send_frame(8'h42, 1'b0, 1'b0, 1'b0);
    expect_frame("R7 resume", v, 8'h42, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_loopback();
    int v;
    lb_en = 1'b1; rx_pin = 1'b0;
    put_bit(1'b1);
    v = vcount; send_frame(8'hE7, 1'b0, 1'b0, 1'b0);
    expect_frame("R6 loopback", v, 8'hE7, 1'b0, 1'b0, 1'b0);
    lb_en = 1'b0; rx_pin = 1'b1; lb_line = 1'b0;
    put_bit(1'b1);
    v = vcount; send_frame(8'h18, 1'b0, 1'b0, 1'b0);
    expect_frame("R6 pin path", v, 8'h18, 1'b0, 1'b0, 1'b0);
    lb_line = 1'b1;
  endtask

  task automatic t_glitch();
    int v;
    v = vcount;
    rx_pin = 1'b0;
    repeat (6) @(negedge clk);
    rx_pin = 1'b1;
    repeat (400) @(negedge clk);
    check(vcount == v, "R1 short low rejected", vcount, v);
    v = vcount; send_frame(8'h69, 1'b0, 1'b0, 1'b0);
    expect_frame("R1 frame after glitch", v, 8'h69, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1; run = 1'b1;
    repeat (40) @(negedge clk);
    t_lengths();
    t_addr();
    t_parity();
    t_stops();
    t_both_errors();
    t_run_drop();
    t_loopback();
    t_glitch();
    check(wide == 0, "R8 strobe width one", wide, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule